// File: doc/BRIEF.md
# Two-Level Trigger Event Buffer

This block sits between a frontend sample stream and the readout path. A first-level trigger pulse opens a capture window that copies a fixed number of valid samples into one slot of an intermediate buffer. Every first-level pulse draws a number from a running event counter, and the captured data keeps that number for as long as it stays in the buffer.

In two-level operation a completed event waits in its slot for a second-level verdict. The verdict arrives as an accept or reject pulse and always applies to the oldest undecided event. Accepted events are streamed out in trigger order. Rejected events, and events whose verdict does not arrive in time, are dropped, and their slot is released in a single cycle. In single-level operation every completed event is forwarded without waiting for a verdict.

The output is a valid/ready stream of sample words. Each word carries its event number, and the first and last words of an event are flagged.

Top module: `trig_event_buffer`

## Requirements
- R1: A first-level pulse is taken when no capture is in progress and at least one slot is free. From the trigger cycle itself onward, the next WIN valid samples (cycles with sampleValid high) are stored in order. Cycles with sampleValid low are skipped.
- R2: An EV_W-bit event counter is 0 after reset and increments by one, wrapping, on every first-level pulse, whether the pulse is taken or dropped. A taken event carries the counter value seen in its trigger cycle on every output word (outEvent).
- R3: In two-level mode (twoLevelMode=1), an event becomes undecided in the cycle after its last sample is stored. An l2Accept pulse marks the oldest undecided event for forwarding, and an l2Reject pulse discards it. Reject wins when both are high. A pulse that arrives while no event is undecided has no effect.
- R4: In single-level mode (twoLevelMode=0), each completed event is forwarded in the cycle after it becomes undecided, and l2Accept and l2Reject are ignored.
- R5: At most SLOTS events are held at once, counting undecided and forwarded-but-unsent events. A first-level pulse that arrives during a capture, or while all slots are held, is dropped and increments l1DropCount.
- R6: In two-level mode, a wait counter starts at 0 in the first cycle an event is the oldest undecided one and rises by one each cycle. If it has reached timeoutLimit in a cycle with no verdict, that event is discarded and timeoutCount increments.
- R7: outValid, outData and outEvent hold steady while outReady is low. A word is taken on a cycle with outValid and outReady both high. Words of an event leave in capture order, outFirst is high on word 0 and outLast on word WIN-1.
- R8: Forwarded events leave in trigger order. A discarded event at the head of the buffer frees its slot in one cycle, with no output words.
- R9: After reset outValid is low, timeoutCount and l1DropCount are 0, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| twoLevelMode | input | 1 | 1: wait for second-level verdict, 0: forward at once |
| timeoutLimit | input | TO_W | Wait-counter value at which an undecided event is dropped |
| sampleValid | input | 1 | Sample present on sampleData |
| sampleData | input | DATA_W | Frontend sample |
| l1Trigger | input | 1 | First-level trigger pulse |
| l2Accept | input | 1 | Second-level accept for oldest undecided event |
| l2Reject | input | 1 | Second-level reject for oldest undecided event |
| outReady | input | 1 | Downstream can take a word |
| outValid | output | 1 | Output word valid |
| outData | output | DATA_W | Output sample word |
| outEvent | output | EV_W | Event number of the output word |
| outFirst | output | 1 | First word of an event |
| outLast | output | 1 | Last word of an event |
| timeoutCount | output | CNT_W | Events dropped by verdict timeout |
| l1DropCount | output | CNT_W | First-level pulses that were dropped |

## Verification
The bench builds the block with a window of three words, which is not a power of two and so exercises the slot address arithmetic. It uses four slots, so a handful of quick triggers fills the buffer and the drop path is hit. A 4-bit event number wraps many times during the random phase, and an 8-bit timeout allows both short limits that expire and long limits that never do. A behavioural queue model is compared with the outputs on every clock while both modes, random back-pressure, gaps in the sample stream, and overlapping or premature verdicts are applied.

// File: rtl/tlt_pkg.sv
package tlt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrSample;   // store sampleData at wrAddr
    logic tagEvent;   // bind tagValue to tagSlot
  } dpStrobe_t;

endpackage

// File: rtl/evbuf_data.sv
module evbuf_data
  import tlt_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SLOTS  = 4,
  parameter int WIN    = 4,
  parameter int EV_W   = 8,
  localparam int DEPTH  = SLOTS * WIN,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [SLOT_W-1:0] tagSlot,
  input  logic [EV_W-1:0]   tagValue,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic [DATA_W-1:0] outData,
  output logic [EV_W-1:0]   outEvent
);

  logic [DATA_W-1:0] sampleMem [DEPTH];
  logic [EV_W-1:0]   evTag     [SLOTS];

  always_ff @(posedge clk) begin
    if (strobe.wrSample) sampleMem[wrAddr] <= sampleData;
  end

  // One tag register per slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (strobe.tagEvent && tagSlot == SLOT_W'(g)) evTag[g] <= tagValue;
    end
  end

  assign outData  = sampleMem[rdAddr];
  assign outEvent = evTag[rdSlot];

endmodule

// File: rtl/evbuf_ctrl.sv
module evbuf_ctrl
  import tlt_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int WIN   = 4,
  parameter int TO_W  = 16,
  parameter int EV_W  = 8,
  parameter int CNT_W = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PTR_W  = SLOT_W + 1,
  localparam int IDX_W  = $clog2(WIN),
  localparam int ADDR_W = $clog2(SLOTS * WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              twoLevelMode,
  input  logic [TO_W-1:0]   timeoutLimit,
  input  logic              sampleValid,
  input  logic              l1Trigger,
  input  logic              l2Accept,
  input  logic              l2Reject,
  input  logic              outReady,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [SLOT_W-1:0] tagSlot,
  output logic [EV_W-1:0]   tagValue,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [SLOT_W-1:0] rdSlot,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast,
  output logic [CNT_W-1:0]  timeoutCount,
  output logic [CNT_W-1:0]  l1DropCount
);

  // Ring pointers with wrap bit: rdPtr <= decPtr <= wrPtr
  logic [PTR_W-1:0] wrPtr, decPtr, rdPtr;
  logic             filling;
  logic [IDX_W-1:0] fillIdx, rdIdx;
  logic [EV_W-1:0]  evCounter;
  logic [SLOTS-1:0] keepFlags;
  logic [TO_W-1:0]  waitTimer;

  logic [PTR_W-1:0]  occupancy;
  logic              bufFull, l1Take, captureNow, fillDone;
  logic [IDX_W-1:0]  curIdx;
  logic              pendingAny, decAdvance, decKeep, decTimeout;
  logic              headReady, headKeep, headSkip, wordTaken, wordLast;
  logic [SLOT_W-1:0] wrSlot, decSlot;

  function automatic logic [ADDR_W-1:0] slotAddr(input logic [SLOT_W-1:0] s,
                                                 input logic [IDX_W-1:0]  i);
    return ADDR_W'(s) * ADDR_W'(WIN) + ADDR_W'(i);
  endfunction

  // ---------------- capture side ----------------
  assign wrSlot     = wrPtr[SLOT_W-1:0];
  assign decSlot    = decPtr[SLOT_W-1:0];
  assign rdSlot     = rdPtr[SLOT_W-1:0];
  assign occupancy  = wrPtr - rdPtr;
  assign bufFull    = (occupancy == PTR_W'(SLOTS));
  assign l1Take     = l1Trigger & ~filling & ~bufFull;
  assign captureNow = (filling | l1Take) & sampleValid;
  assign curIdx     = filling ? fillIdx : '0;
  assign fillDone   = captureNow && (curIdx == IDX_W'(WIN - 1));

  always_comb begin
    strobe          = '0;
    strobe.wrSample = captureNow;
    strobe.tagEvent = l1Take;
  end
  assign wrAddr   = slotAddr(wrSlot, curIdx);
  assign tagSlot  = wrSlot;
  assign tagValue = evCounter;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filling     <= 1'b0;
      fillIdx     <= '0;
      wrPtr       <= '0;
      evCounter   <= '0;
      l1DropCount <= '0;
    end else begin
      if (l1Trigger) evCounter <= evCounter + EV_W'(1);
      if (l1Trigger && !l1Take) l1DropCount <= l1DropCount + CNT_W'(1);
      if (fillDone) begin
        filling <= 1'b0;
        fillIdx <= '0;
        wrPtr   <= wrPtr + PTR_W'(1);
      end else if (captureNow) begin
        filling <= 1'b1;
        fillIdx <= curIdx + IDX_W'(1);
      end else if (l1Take) begin
        filling <= 1'b1;
        fillIdx <= '0;
      end
    end
  end

  // ---------------- verdict side ----------------
  assign pendingAny = (decPtr != wrPtr);

  always_comb begin
    decAdvance = 1'b0;
    decKeep    = 1'b0;
    decTimeout = 1'b0;
    if (pendingAny) begin
      if (!twoLevelMode) begin
        decAdvance = 1'b1;
        decKeep    = 1'b1;
      end else if (l2Reject) begin
        decAdvance = 1'b1;
      end else if (l2Accept) begin
        decAdvance = 1'b1;
        decKeep    = 1'b1;
      end else if (waitTimer >= timeoutLimit) begin
        decAdvance = 1'b1;
        decTimeout = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decPtr       <= '0;
      keepFlags    <= '0;
      waitTimer    <= '0;
      timeoutCount <= '0;
    end else begin
      if (decAdvance) begin
        decPtr            <= decPtr + PTR_W'(1);
        keepFlags[decSlot] <= decKeep;
      end
      if (!pendingAny || decAdvance) waitTimer <= '0;
      else                           waitTimer <= waitTimer + TO_W'(1);
      if (decTimeout) timeoutCount <= timeoutCount + CNT_W'(1);
    end
  end

  // ---------------- output side ----------------
  assign headReady = (rdPtr != decPtr);
  assign headKeep  = keepFlags[rdSlot];
  assign headSkip  = headReady & ~headKeep;
  assign outValid  = headReady & headKeep;
  assign wordTaken = outValid & outReady;
  assign wordLast  = (rdIdx == IDX_W'(WIN - 1));
  assign outFirst  = outValid && (rdIdx == '0);
  assign outLast   = outValid && wordLast;
  assign rdAddr    = slotAddr(rdSlot, rdIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      rdIdx <= '0;
    end else if (headSkip) begin
      rdPtr <= rdPtr + PTR_W'(1);
    end else if (wordTaken) begin
      if (wordLast) begin
        rdIdx <= '0;
        rdPtr <= rdPtr + PTR_W'(1);
      end else begin
        rdIdx <= rdIdx + IDX_W'(1);
      end
    end
  end

  // ---------------- assertions ----------------
  p_fill_room_r1: assert property (@(posedge clk) disable iff (!rstN)
    filling |-> occupancy < PTR_W'(SLOTS));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= PTR_W'(SLOTS));

  p_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    (decPtr - rdPtr) <= occupancy);

  p_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!twoLevelMode && pendingAny) |=> decPtr != $past(decPtr));

  p_reject_r3: assert property (@(posedge clk) disable iff (!rstN)
    (twoLevelMode && pendingAny && l2Reject) |=> !keepFlags[$past(decSlot)]);

  p_timeout_r6: assert property (@(posedge clk) disable iff (!rstN)
    (twoLevelMode && pendingAny && !l2Accept && !l2Reject && waitTimer >= timeoutLimit)
      |=> timeoutCount != $past(timeoutCount));

  p_last_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> rdPtr == $past(rdPtr) + PTR_W'(1));

endmodule

// File: rtl/trig_event_buffer.sv
module trig_event_buffer
  import tlt_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SLOTS  = 4,
  parameter int WIN    = 4,
  parameter int EV_W   = 8,
  parameter int TO_W   = 16,
  parameter int CNT_W  = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = $clog2(SLOTS * WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              twoLevelMode,
  input  logic [TO_W-1:0]   timeoutLimit,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              l1Trigger,
  input  logic              l2Accept,
  input  logic              l2Reject,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [EV_W-1:0]   outEvent,
  output logic              outFirst,
  output logic              outLast,
  output logic [CNT_W-1:0]  timeoutCount,
  output logic [CNT_W-1:0]  l1DropCount
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [SLOT_W-1:0] tagSlot, rdSlot;
  logic [EV_W-1:0]   tagValue;

  evbuf_ctrl #(
    .SLOTS(SLOTS), .WIN(WIN), .TO_W(TO_W), .EV_W(EV_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .twoLevelMode(twoLevelMode), .timeoutLimit(timeoutLimit),
    .sampleValid(sampleValid), .l1Trigger(l1Trigger), .l2Accept(l2Accept),
    .l2Reject(l2Reject), .outReady(outReady), .strobe(strobe), .wrAddr(wrAddr),
    .tagSlot(tagSlot), .tagValue(tagValue), .rdAddr(rdAddr), .rdSlot(rdSlot),
    .outValid(outValid), .outFirst(outFirst), .outLast(outLast),
    .timeoutCount(timeoutCount), .l1DropCount(l1DropCount)
  );

  evbuf_data #(
    .DATA_W(DATA_W), .SLOTS(SLOTS), .WIN(WIN), .EV_W(EV_W)
  ) u_data (
    .clk(clk), .strobe(strobe), .wrAddr(wrAddr), .sampleData(sampleData),
    .tagSlot(tagSlot), .tagValue(tagValue), .rdAddr(rdAddr), .rdSlot(rdSlot),
    .outData(outData), .outEvent(outEvent)
  );

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData) && $stable(outEvent));

endmodule

// File: tb/tb_trig_event_buffer.sv
module tb_trig_event_buffer;

  localparam int DATA_W = 12;
  localparam int SLOTS  = 4;
  localparam int WIN    = 3;
  localparam int EV_W   = 4;
  localparam int TO_W   = 8;
  localparam int CNT_W  = 16;
  localparam int EVN    = 1 << EV_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              twoLevelMode = 1'b0;
  logic [TO_W-1:0]   timeoutLimit = '0;
  logic              sampleValid = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic              l1Trigger = 1'b0, l2Accept = 1'b0, l2Reject = 1'b0;
  logic              outReady = 1'b0;
  logic              outValid, outFirst, outLast;
  logic [DATA_W-1:0] outData;
  logic [EV_W-1:0]   outEvent;
  logic [CNT_W-1:0]  timeoutCount, l1DropCount;

  trig_event_buffer #(
    .DATA_W(DATA_W), .SLOTS(SLOTS), .WIN(WIN), .EV_W(EV_W), .TO_W(TO_W), .CNT_W(CNT_W)
  ) dut (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int validPct = 100, readyPct = 100;
  int evOut = 0;
  bit prevValid = 0, prevLast = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct packed {
    logic [EV_W-1:0]              ev;
    logic [WIN-1:0][DATA_W-1:0]   w;
  } rec_t;

  rec_t pendQ[$];
  rec_t outRec[$];
  bit   outKeep[$];
  rec_t cur;
  bit   mFilling;
  int   mCnt, mIdx, mEv, mTimer, mDrop, mTmo, used;
  bit   decided, keepIt;

  always @(posedge clk) begin
    if (!rstN) begin
      pendQ.delete(); outRec.delete(); outKeep.delete();
      mFilling = 0; mCnt = 0; mIdx = 0; mEv = 0; mTimer = 0; mDrop = 0; mTmo = 0;
    end else begin
      used = pendQ.size() + outRec.size();
      // output stage
      if (outRec.size() > 0) begin
        if (!outKeep[0]) begin
          void'(outRec.pop_front()); void'(outKeep.pop_front());
        end else if (outReady) begin
          if (mIdx == WIN - 1) begin
            mIdx = 0; void'(outRec.pop_front()); void'(outKeep.pop_front());
          end else mIdx++;
        end
      end
      // verdict stage
      if (pendQ.size() > 0) begin
        decided = 0; keepIt = 0;
        if (!twoLevelMode) begin decided = 1; keepIt = 1; end
        else if (l2Reject) decided = 1;
        else if (l2Accept) begin decided = 1; keepIt = 1; end
        else if (mTimer >= int'(timeoutLimit)) begin decided = 1; mTmo++; end
        if (decided) begin
          outRec.push_back(pendQ[0]); outKeep.push_back(keepIt);
          void'(pendQ.pop_front()); mTimer = 0;
        end else mTimer++;
      end else mTimer = 0;
      // capture stage
      if (l1Trigger) begin
        if (!mFilling && used < SLOTS) begin
          mFilling = 1; mCnt = 0; cur = '0; cur.ev = EV_W'(mEv);
        end else mDrop++;
        mEv = (mEv + 1) % EVN;
      end
      if (mFilling && sampleValid) begin
        cur.w[mCnt] = sampleData; mCnt++;
        if (mCnt == WIN) begin pendQ.push_back(cur); mFilling = 0; end
      end
    end
  end

  // ---------------- per-cycle compare ----------------
  always @(negedge clk) begin
    if (!rstN) begin
      check("R9 outValid in reset", int'(outValid), 0);
      prevValid = 0; prevLast = 0;
    end else begin
      if (prevValid && prevLast && outReady) evOut++;
      prevValid = outValid; prevLast = outLast;
      check("R7 R8 outValid", int'(outValid), int'(outRec.size() > 0 && outKeep[0]));
      if (outRec.size() > 0 && outKeep[0] && outValid) begin
        check("R1 outData", int'(outData), int'(outRec[0].w[mIdx]));
        check("R2 outEvent", int'(outEvent), int'(outRec[0].ev));
        check("R7 outFirst", int'(outFirst), int'(mIdx == 0));
        check("R7 outLast", int'(outLast), int'(mIdx == WIN - 1));
      end
      check("R5 l1DropCount", int'(l1DropCount), mDrop % (1 << CNT_W));
      check("R6 timeoutCount", int'(timeoutCount), mTmo % (1 << CNT_W));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit l1, input bit acc, input bit rej);
    @(negedge clk); #1;
    l1Trigger   = l1; l2Accept = acc; l2Reject = rej;
    sampleValid = ($urandom % 100) < validPct;
    sampleData  = DATA_W'($urandom);
    outReady    = ($urandom % 100) < readyPct;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  int base;

  initial begin
    timeoutLimit = 8'd100;
    repeat (4) @(negedge clk);
    check("R9 timeoutCount after reset", int'(timeoutCount), 0);
    check("R9 l1DropCount after reset", int'(l1DropCount), 0);
    #1 rstN = 1'b1;

    // single-level: verdict pulses ignored
    twoLevelMode = 0;
    base = evOut;
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 0); idle(3); step(0, 0, 1); idle(6);
    end
    idle(20);
    check("R4 single-level events forwarded", evOut - base, 3);

    // two-level: accept, reject, both, premature
    twoLevelMode = 1;
    base = evOut;
    step(0, 1, 0); idle(3);
    step(1, 0, 0); idle(8); step(0, 1, 0); idle(8);
    step(1, 0, 0); idle(8); step(0, 0, 1); idle(8);
    step(1, 0, 0); idle(8); step(0, 1, 1); idle(8);
    step(1, 0, 0); idle(8); step(0, 1, 0); idle(15);
    check("R3 accepted events forwarded", evOut - base, 2);

    // fill buffer, busy and full drops
    timeoutLimit = 8'd200; readyPct = 0;
    step(1, 0, 0); step(1, 0, 0); idle(6);
    for (int k = 0; k < 5; k++) begin step(1, 0, 0); idle(6); end
    check("R5 drops while busy or full", int'(l1DropCount), 3);
    readyPct = 100; base = evOut;
    for (int k = 0; k < 4; k++) begin step(0, 1, 0); idle(2); end
    idle(30);
    check("R8 held events drained", evOut - base, 4);

    // timeout then reuse of the freed slot
    timeoutLimit = 8'd5; base = evOut;
    step(1, 0, 0); idle(30);
    check("R6 timeout discards event", int'(timeoutCount), 1);
    check("R6 timed-out event not sent", evOut - base, 0);
    step(1, 0, 0); idle(6); step(0, 1, 0); idle(15);
    check("R8 slot reused after discard", evOut - base, 1);

    // random two-level traffic
    timeoutLimit = 8'd12; validPct = 70; readyPct = 60;
    for (int i = 0; i < 3000; i++)
      step(($urandom % 100) < 6, ($urandom % 100) < 5, ($urandom % 100) < 2);
    // random single-level traffic
    twoLevelMode = 0;
    for (int i = 0; i < 600; i++)
      step(($urandom % 100) < 6, ($urandom % 100) < 5, ($urandom % 100) < 5);
    readyPct = 100; idle(40);
    finishRun();
  end

endmodule